// File: doc/BRIEF.md
# DDR Write Data Capture (x16, two byte strobes)

This block sits behind the pads of a 16-bit double-data-rate memory device and gathers the write data of a burst. A write command arms it with a starting column and a burst length. From then on each byte lane watches its own data strobe. The lower strobe governs the low byte of the data bus and the upper strobe governs the high byte. The strobes and the bus are oversampled by the core clock, so a strobe transition appears as a change between two consecutive samples.

The strobe idles low after arming. The first beat of a lane is its first low-to-high transition. Every later transition of that lane, in either direction, is a further beat. When both lanes hold the same beat, the block emits one word. The word carries its column, taken from the sequential wrapped burst order, and per-byte enables taken from the inverted data-mask inputs. The beat that completes the programmed length raises a last-beat pulse and disarms capture. A truncating command (read or precharge) also raises the pulse and disarms capture, which is how a masked, shortened burst stops writing.

The controller has three states. IDLE waits for a command. PREAMBLE is armed and waits for a first rising strobe edge. BURST collects beats. The transitions are: IDLE to PREAMBLE on a write command (arm); PREAMBLE to BURST when any lane has taken its first beat; PREAMBLE or BURST back to IDLE on the final beat or on a truncating command (disarm).

Top module: `ddr_wr_capture`

## Requirements
- R1: After reset, word_valid, last_beat, word_data, word_col and word_be are all zero and the block is idle.
- R2: Strobe transitions while no write is armed produce no word and no last_beat.
- R3: Once armed, a lane ignores falling transitions until it sees its first rising transition, and that rising transition captures beat 0 for the starting column.
- R4: After its first beat, a lane captures a beat on every strobe transition, rising or falling.
- R5: dqs[k] and dm[k] belong to dq[8k+7:8k]. Bit 0 is the lower byte. A word is emitted, with word_data holding the byte each lane captured for that beat, once both lanes have captured that beat.
- R6: wr_bl selects the burst length: 0 gives 2 beats, 1 gives 4, and 2 or 3 give 8. Beat i carries column (C & ~(L-1)) | ((C+i) & (L-1)), where C is wr_col and L is the burst length.
- R7: word_be[k] is the inverse of dm[k] sampled with lane k's beat. A masked byte is still reported, with its enable low.
- R8: last_beat is high together with the word that completes the burst length. Later strobe transitions produce nothing until the next write command.
- R9: trunc_cmd while armed raises last_beat for one cycle, without a word unless one completes in the same cycle, and disarms capture. trunc_cmd while idle has no effect.
- R10: A write command received while armed is ignored: the words of the running burst keep their columns and their count.
- R11: The lanes count beats independently. An upper-lane strobe lagging the lower one by less than one beat still pairs beats in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, oversamples the strobes |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_cmd | input | 1 | One-cycle write command pulse |
| wr_col | input | COL_W | Starting column of the write |
| wr_bl | input | 2 | Burst length code |
| trunc_cmd | input | 1 | One-cycle truncating command (read or precharge) |
| dqs | input | LANES | Per-byte data strobes |
| dq | input | DQ_W | Data bus |
| dm | input | LANES | Per-byte data masks, high means masked |
| word_valid | output | 1 | A captured word is present |
| word_data | output | DQ_W | Captured word |
| word_col | output | COL_W | Column of the captured word |
| word_be | output | LANES | Byte enables of the word |
| last_beat | output | 1 | Burst finished or truncated |

## Verification
The hardest state to reach from the ports is a burst cut short by a truncating command while the lanes are skewed. If that burst left the strobe high, the next write is armed with the strobe still high, and its first falling edge must be skipped as preamble. The stimulus reaches this with directed bursts: one truncated after an odd number of skewed beats, and one armed with the strobe held high before the preamble fall. Seeded random bursts then combine truncation, lane skew, masks, mid-burst write commands and stray strobe edges after each burst. A bench model predicts every word's data, column, enables and last flag.

// File: rtl/ddrw_pkg.sv
package ddrw_pkg;

    localparam int BEAT_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_PREAMBLE = 2'd1,
        ST_BURST    = 2'd2
    } cap_state_e;

    // burst length code to beat count; codes 2 and 3 both mean eight
    function automatic logic [BEAT_W-1:0] beats_of(input logic [1:0] code);
        case (code)
            2'd0:    return BEAT_W'(2);
            2'd1:    return BEAT_W'(4);
            default: return BEAT_W'(8);
        endcase
    endfunction

endpackage

// File: rtl/ddrw_lane.sv
module ddrw_lane
    import ddrw_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic              disarm_i,
    input  logic              take_i,
    input  logic [BEAT_W-1:0] lim_i,
    input  logic              dqs_i,
    input  logic [LANE_W-1:0] dq_i,
    input  logic              dm_i,
    output logic              have_o,
    output logic              started_o,
    output logic [LANE_W-1:0] byte_o,
    output logic              mask_o
);

    logic              dqs_q, dqs_p_q, dm_q;
    logic [LANE_W-1:0] dq_q;
    logic              armed_q, started_q, have_q, mask_q;
    logic [BEAT_W-1:0] cnt_q;
    logic [LANE_W-1:0] byte_q;
    logic              rise, toggle, hit, accept;

    // input sampling; data and strobe share the same register stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dqs_q   <= 1'b0;
            dqs_p_q <= 1'b0;
            dq_q    <= '0;
            dm_q    <= 1'b0;
        end else begin
            dqs_q   <= dqs_i;
            dqs_p_q <= dqs_q;
            dq_q    <= dq_i;
            dm_q    <= dm_i;
        end
    end

    always_comb begin
        rise   = dqs_q & ~dqs_p_q;
        toggle = dqs_q ^ dqs_p_q;
        hit    = started_q ? toggle : rise;
        accept = armed_q && hit && (cnt_q < lim_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q   <= 1'b0;
            started_q <= 1'b0;
            have_q    <= 1'b0;
            cnt_q     <= '0;
            byte_q    <= '0;
            mask_q    <= 1'b0;
        end else if (arm_i) begin
            armed_q   <= 1'b1;
            started_q <= 1'b0;
            have_q    <= 1'b0;
            cnt_q     <= '0;
        end else if (disarm_i) begin
            armed_q   <= 1'b0;
            started_q <= 1'b0;
            have_q    <= 1'b0;
        end else if (accept) begin
            byte_q    <= dq_q;
            mask_q    <= dm_q;
            have_q    <= 1'b1;
            started_q <= 1'b1;
            cnt_q     <= cnt_q + 1'b1;
        end else if (take_i) begin
            have_q    <= 1'b0;
        end
    end

    assign have_o    = have_q;
    assign started_o = started_q;
    assign byte_o    = byte_q;
    assign mask_o    = mask_q;

    // first beat of a lane is always a low-to-high strobe change
    assert_first_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(started_q) |-> dqs_p_q);

    // nothing is held once capture is disarmed
    assert_idle_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_q |-> !have_q);

    // a lane never takes more beats than the burst length
    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (cnt_q <= lim_i));

endmodule

// File: rtl/ddrw_colgen.sv
module ddrw_colgen
    import ddrw_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0]  base_i,
    input  logic [BEAT_W-1:0] beat_i,
    input  logic [BEAT_W-1:0] lim_i,
    output logic [COL_W-1:0]  col_o
);

    logic [COL_W-1:0] span, off;

    // sequential order, wrapping inside the aligned burst block
    always_comb begin
        span  = COL_W'(lim_i) - COL_W'(1);
        off   = base_i + COL_W'(beat_i);
        col_o = (base_i & ~span) | (off & span);
    end

endmodule

// File: rtl/ddrw_ctrl.sv
module ddrw_ctrl
    import ddrw_pkg::*;
#(
    parameter int LANES  = 2,
    parameter int LANE_W = 8,
    parameter int COL_W  = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_cmd_i,
    input  logic [COL_W-1:0]        wr_col_i,
    input  logic [1:0]              wr_bl_i,
    input  logic                    trunc_i,
    input  logic [LANES-1:0]        have_i,
    input  logic [LANES-1:0]        started_i,
    input  logic [LANES*LANE_W-1:0] bytes_i,
    input  logic [LANES-1:0]        masks_i,
    output logic                    arm_o,
    output logic                    disarm_o,
    output logic                    take_o,
    output logic [BEAT_W-1:0]       lim_o,
    output logic                    word_valid_o,
    output logic [LANES*LANE_W-1:0] word_data_o,
    output logic [COL_W-1:0]        word_col_o,
    output logic [LANES-1:0]        word_be_o,
    output logic                    last_o
);

    cap_state_e        state_q, state_d;
    logic [BEAT_W-1:0] beat_q, lim_q;
    logic [COL_W-1:0]  base_q, col_w;
    logic              arm, fire, final_beat, trunc_hit, done;

    ddrw_colgen #(.COL_W(COL_W)) i_colgen (
        .base_i (base_q),
        .beat_i (beat_q),
        .lim_i  (lim_q),
        .col_o  (col_w)
    );

    always_comb begin
        fire       = (state_q != ST_IDLE) && (&have_i);
        final_beat = fire && (beat_q == lim_q - 1'b1);
        trunc_hit  = (state_q != ST_IDLE) && trunc_i;
        done       = final_beat || trunc_hit;
    end

    // next state
    always_comb begin
        state_d = state_q;
        arm     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_cmd_i) begin
                    state_d = ST_PREAMBLE;
                    arm     = 1'b1;
                end
            end
            ST_PREAMBLE: begin
                if (done)            state_d = ST_IDLE;
                else if (|started_i) state_d = ST_BURST;
            end
            ST_BURST: begin
                if (done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // burst context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            lim_q  <= beats_of(2'd0);
            beat_q <= '0;
        end else if (arm) begin
            base_q <= wr_col_i;
            lim_q  <= beats_of(wr_bl_i);
            beat_q <= '0;
        end else if (fire) begin
            beat_q <= beat_q + 1'b1;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_valid_o <= 1'b0;
            word_data_o  <= '0;
            word_col_o   <= '0;
            word_be_o    <= '0;
            last_o       <= 1'b0;
        end else begin
            word_valid_o <= fire;
            last_o       <= done;
            if (fire) begin
                word_data_o <= bytes_i;
                word_col_o  <= col_w;
                word_be_o   <= ~masks_i;
            end
        end
    end

    assign arm_o    = arm;
    assign disarm_o = done;
    assign take_o   = fire;
    assign lim_o    = lim_q;

    // a last pulse always leaves the controller idle
    assert_last_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> (state_q == ST_IDLE));

    // last is a single-cycle pulse
    assert_last_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> !last_o);

    // words only come from an armed controller
    assert_word_armed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |-> ($past(state_q) != ST_IDLE));

    // beat index stays below the burst length while armed
    assert_beat_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (beat_q < lim_q));

    // a write command while armed leaves the column untouched
    assert_ignore_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != ST_IDLE) && wr_cmd_i) |=> $stable(base_q));

endmodule

// File: rtl/ddr_wr_capture.sv
module ddr_wr_capture
    import ddrw_pkg::*;
#(
    parameter int DQ_W  = 16,
    parameter int LANES = 2,
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_cmd,
    input  logic [COL_W-1:0] wr_col,
    input  logic [1:0]       wr_bl,
    input  logic             trunc_cmd,
    input  logic [LANES-1:0] dqs,
    input  logic [DQ_W-1:0]  dq,
    input  logic [LANES-1:0] dm,
    output logic             word_valid,
    output logic [DQ_W-1:0]  word_data,
    output logic [COL_W-1:0] word_col,
    output logic [LANES-1:0] word_be,
    output logic             last_beat
);

    localparam int LANE_W = DQ_W / LANES;

    logic              arm, disarm, take;
    logic [BEAT_W-1:0] lim;
    logic [LANES-1:0]  have, started, masks;
    logic [DQ_W-1:0]   bytes;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        ddrw_lane #(.LANE_W(LANE_W)) i_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .arm_i     (arm),
            .disarm_i  (disarm),
            .take_i    (take),
            .lim_i     (lim),
            .dqs_i     (dqs[k]),
            .dq_i      (dq[k*LANE_W +: LANE_W]),
            .dm_i      (dm[k]),
            .have_o    (have[k]),
            .started_o (started[k]),
            .byte_o    (bytes[k*LANE_W +: LANE_W]),
            .mask_o    (masks[k])
        );
    end

    ddrw_ctrl #(.LANES(LANES), .LANE_W(LANE_W), .COL_W(COL_W)) i_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_cmd_i     (wr_cmd),
        .wr_col_i     (wr_col),
        .wr_bl_i      (wr_bl),
        .trunc_i      (trunc_cmd),
        .have_i       (have),
        .started_i    (started),
        .bytes_i      (bytes),
        .masks_i      (masks),
        .arm_o        (arm),
        .disarm_o     (disarm),
        .take_o       (take),
        .lim_o        (lim),
        .word_valid_o (word_valid),
        .word_data_o  (word_data),
        .word_col_o   (word_col),
        .word_be_o    (word_be),
        .last_o       (last_beat)
    );

endmodule

// File: tb/test_ddr_wr_capture.sv
module test_ddr_wr_capture;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;
    localparam int QD         = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_cmd = 1'b0;
    logic [9:0]  wr_col = '0;
    logic [1:0]  wr_bl = '0;
    logic        trunc_cmd = 1'b0;
    logic [1:0]  dqs = '0;
    logic [15:0] dq = '0;
    logic [1:0]  dm = '0;
    logic        word_valid, last_beat;
    logic [15:0] word_data;
    logic [9:0]  word_col;
    logic [1:0]  word_be;

    ddr_wr_capture i_ddr_wr_capture (
        .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .wr_col(wr_col), .wr_bl(wr_bl),
        .trunc_cmd(trunc_cmd), .dqs(dqs), .dq(dq), .dm(dm),
        .word_valid(word_valid), .word_data(word_data), .word_col(word_col),
        .word_be(word_be), .last_beat(last_beat)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // expected word store: written by the stimulus, read by the monitor
    logic [15:0] e_data [QD];
    logic [9:0]  e_col  [QD];
    logic [1:0]  e_be   [QD];
    logic        e_last [QD];
    int wr_idx = 0;
    int rd_idx = 0;
    int n_chk = 0, n_bad = 0, m_chk = 0, m_bad = 0;
    int got_words = 0, got_last = 0, got_lone = 0;

    function automatic int bl_beats(input logic [1:0] c);
        return (c == 2'd0) ? 2 : (c == 2'd1) ? 4 : 8;
    endfunction

    function automatic logic [9:0] exp_col(input logic [9:0] b, input int i, input logic [1:0] c);
        logic [9:0] m;
        m = 10'(bl_beats(c) - 1);
        return (b & ~m) | ((b + 10'(i)) & m);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // monitor, sampling away from the active edge
    always @(negedge clk) begin
        if (rst_n && word_valid) begin
            got_words++;
            if (last_beat) got_last++;
            m_chk++;
            if (rd_idx >= wr_idx) begin
                m_bad++;
                $display("FAIL R2 unexpected word actual=%0h expected=none", word_data);
            end else begin
                m_chk += 3;
                if (word_data !== e_data[rd_idx]) begin
                    m_bad++;
                    $display("FAIL R5 data actual=%0h expected=%0h", word_data, e_data[rd_idx]);
                end
                if (word_col !== e_col[rd_idx]) begin
                    m_bad++;
                    $display("FAIL R6 column actual=%0h expected=%0h", word_col, e_col[rd_idx]);
                end
                if (word_be !== e_be[rd_idx]) begin
                    m_bad++;
                    $display("FAIL R7 enables actual=%0h expected=%0h", word_be, e_be[rd_idx]);
                end
                if (last_beat !== e_last[rd_idx]) begin
                    m_bad++;
                    $display("FAIL R8 last actual=%0h expected=%0h", last_beat, e_last[rd_idx]);
                end
                rd_idx++;
            end
        end else if (rst_n && last_beat) begin
            got_last++;
            got_lone++;
        end
    end

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic lane_edge(input int k, input logic [7:0] b, input logic m);
        dq[k*8 +: 8] = b;
        dm[k] = m;
        dqs[k] = ~dqs[k];
    endtask

    task automatic stray_edges(input int n);
        for (int i = 0; i < n; i++) begin
            dqs = ~dqs;
            dq  = 16'($urandom);
            wait_n(3);
        end
    endtask

    task automatic run_burst(input logic [9:0] col, input logic [1:0] blc, input bit pre_high,
                             input bit skew, input int trunc_k, input bit mid_cmd,
                             input bit use_fm, input logic [1:0] fm);
        int nb, nsend, last0, lone0, words0;
        logic [7:0] b0, b1;
        logic m0, m1;
        nb = bl_beats(blc);
        nsend = (trunc_k > 0) ? trunc_k : nb;
        last0 = got_last; lone0 = got_lone; words0 = got_words;
        if (pre_high) begin
            dqs = 2'b11;      // rises while idle: ignored
            wait_n(4);
        end
        wr_cmd = 1'b1; wr_col = col; wr_bl = blc;
        wait_n(1);
        wr_cmd = 1'b0; wr_col = 10'($urandom); wr_bl = 2'($urandom);
        wait_n(2);
        if (pre_high) begin
            dqs = 2'b00;      // R3: falling change while armed, before first rise
            wait_n(4);
        end
        for (int i = 0; i < nsend; i++) begin
            b0 = 8'($urandom); b1 = 8'($urandom);
            m0 = use_fm ? fm[0] : (($urandom % 4) == 0);
            m1 = use_fm ? fm[1] : (($urandom % 4) == 0);
            e_data[wr_idx] = {b1, b0};
            e_col[wr_idx]  = exp_col(col, i, blc);
            e_be[wr_idx]   = {~m1, ~m0};
            e_last[wr_idx] = (trunc_k == 0) && (i == nb - 1);
            wr_idx++;
            lane_edge(0, b0, m0);
            if (!skew) lane_edge(1, b1, m1);
            wait_n(1);
            if (skew) begin  // R11: upper lane lags by one cycle
                lane_edge(1, b1, m1);
                wait_n(1);
            end
            wait_n(2 + int'($urandom % 3));
            if (mid_cmd && i == 0) begin  // R10: command while armed
                wr_cmd = 1'b1; wr_col = col ^ 10'h155; wr_bl = ~blc;
                wait_n(1);
                wr_cmd = 1'b0;
                wait_n(1);
            end
        end
        if (trunc_k > 0) begin
            wait_n(5);
            trunc_cmd = 1'b1;
            wait_n(1);
            trunc_cmd = 1'b0;
            wait_n(2);
            stray_edges((nsend % 2 == 1) ? 1 : 2);   // R9: ignored after truncation
        end
        stray_edges(2);                               // R8: ignored after the burst
        wait_n(8);
        chk(rd_idx == wr_idx, "R8", "all expected words delivered", 32'(rd_idx), 32'(wr_idx));
        chk(got_words - words0 == nsend, "R4", "word count of burst", 32'(got_words - words0), 32'(nsend));
        chk(got_last - last0 == 1, "R8", "one last pulse per burst", 32'(got_last - last0), 32'd1);
        if (trunc_k > 0)
            chk(got_lone - lone0 == 1, "R9", "lone last on truncation", 32'(got_lone - lone0), 32'd1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        wait_n(3);
        // R1: reset state
        chk({word_valid, last_beat} == 2'b00, "R1", "valid/last in reset", 32'({word_valid, last_beat}), 32'd0);
        chk(word_be == 2'b00 && word_col == 10'd0 && word_data == 16'd0, "R1", "outputs in reset",
            32'({word_be, word_col}), 32'd0);
        rst_n = 1'b1;
        wait_n(2);
        // R2: strobe activity with nothing armed
        stray_edges(4);
        wait_n(6);
        chk(got_words == 0 && got_last == 0, "R2", "no output while idle", 32'(got_words + got_last), 32'd0);
        // R9: truncation while idle
        trunc_cmd = 1'b1; wait_n(1); trunc_cmd = 1'b0;
        wait_n(5);
        chk(got_last == 0, "R9", "idle truncation ignored", 32'(got_last), 32'd0);

        run_burst(10'h3FD, 2'd2, 1'b0, 1'b0, 0, 1'b0, 1'b0, 2'b00); // R6: BL8 wrap
        run_burst(10'h006, 2'd1, 1'b0, 1'b0, 0, 1'b0, 1'b1, 2'b10); // R7: upper byte masked
        run_burst(10'h011, 2'd0, 1'b1, 1'b0, 0, 1'b0, 1'b1, 2'b01); // R3: strobe high at arm
        run_burst(10'h0A5, 2'd2, 1'b0, 1'b1, 3, 1'b0, 1'b1, 2'b11); // R9 + R11: truncated, skewed
        run_burst(10'h1F2, 2'd1, 1'b1, 1'b0, 0, 1'b1, 1'b0, 2'b00); // R10: command mid burst
        run_burst(10'h2C3, 2'd3, 1'b0, 1'b1, 0, 1'b0, 1'b0, 2'b00); // R6: code 3 means eight

        for (int n = 0; n < 40; n++) begin
            logic [1:0] c;
            int tk;
            c = 2'($urandom);
            tk = (($urandom % 5) == 0) ? 1 + int'($urandom % (bl_beats(c) - 1)) : 0;
            run_burst(10'($urandom), c, ($urandom % 6) == 0, ($urandom % 2) == 1, tk,
                      ($urandom % 6) == 0, 1'b0, 2'b00);
        end

        wait_n(4);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + m_chk, n_bad + m_bad);
        $finish;
    end

    initial begin
        wait_n(WATCHDOG);
        $display("FAIL watchdog run did not finish actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + m_chk + 1, n_bad + m_bad + 1);
        $finish;
    end

endmodule